// File: doc/BRIEF.md
# Audio Codec Startup Command Sequencer

This block brings a serially programmed stereo audio codec into a known operating state after reset. When it sees a start pulse it emits a fixed series of nine command bytes. Each byte carries a flag that marks it as an address phase or a data phase. A separate serial shifter takes each byte through a valid/ready handshake and drives the codec's control pins. The shifter is not part of this block.

The codec is programmed through two levels of addressing. An address byte selects either the status bank or the direct data bank. The bytes that follow pick a sub-register through their top bits. Extended registers are reached by a pair of data bytes: one carries the extended register number and the next carries its payload. Every field is a parameter of the top module: clock ratio, serial format, filter, gains, polarities, power, volume, tone, de-emphasis, mute, microphone gain and mixer mode. The sequencer builds each byte from those fields. The defaults give a 384fs, MSB-justified setup with full volume, flat tone, mute off and channel-1 microphone input at gain code 6.

After the last byte has been accepted, `done` rises. It stays high until a new start pulse, and that pulse runs the whole series again.

Top module: `codec_boot_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cmdValid` and `done` are 0.
- R2: A start pulse seen while the block is idle or done makes `cmdValid` high on the next cycle, with the first byte (the status-bank address) on `cmdByte`.
- R3: Address bytes have `cmdIsAddr`=1 and the value 0x14 OR a 2-bit bank code in bits 1:0 (10 = status bank, 00 = direct data bank). With the defaults they are 0x16 and 0x14. All other bytes have `cmdIsAddr`=0.
- R4: The first status byte has bit 7 = 0, reset in bit 6, clock ratio in bits 5:4 (01 = 384fs), serial format in bits 3:1 (100 = MSB-justified) and DC filter in bit 0. The default value is 0x59.
- R5: The second status byte has bit 7 = 1, then from bit 6 down to bit 0: DAC gain, ADC gain, ADC polarity, DAC polarity, double speed, ADC power, DAC power. The default value is 0x83.
- R6: Direct data bytes carry a sub-register code in bits 7:6. Code 00 carries volume in bits 5:0, default 0x00. Code 01 carries bass in bits 5:2 and treble in bits 1:0, default 0x40. Code 10 carries de-emphasis in bits 4:3, mute in bit 2 and filter mode in bits 1:0, default 0x80.
- R7: An extended write is 0xC0 OR the 3-bit register number (register 2 gives 0xC2), followed by 0xE0 OR microphone gain in bits 4:2 and mixer mode in bits 1:0. The default second byte is 0xF9.
- R8: The nine bytes leave in this order: status address, status byte 1, status byte 2, data address, volume, tone, de-emphasis/mute, extended address, extended data.
- R9: While `cmdValid` is high and `cmdReady` is low, `cmdByte` and `cmdIsAddr` hold their values.
- R10: The sequence advances by exactly one byte on each cycle in which both `cmdValid` and `cmdReady` are high, and never on any other cycle.
- R11: In the cycle after the ninth byte is accepted, `cmdValid` is 0 and `done` is 1. `done` then stays 1 until a start pulse arrives.
- R12: A start pulse that arrives while bytes are still being issued has no effect: the current byte and the position in the sequence are kept.
- R13: A start pulse seen while `done` is 1 clears `done` and issues the whole sequence again from the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the configuration series |
| cmdReady | input | 1 | Shifter can take the offered byte |
| cmdValid | output | 1 | A command byte is offered |
| cmdByte | output | 8 | Command byte |
| cmdIsAddr | output | 1 | 1 = address phase, 0 = data phase |
| done | output | 1 | Whole series accepted |

## Verification
Every output comes from registers. A start pulse shows as `cmdValid` and the first byte one edge later. An accepted byte is replaced by the next one at the same edge that takes it. `done` rises one edge after the ninth acceptance. The bench drives `ready` at falling edges and reads outputs there. A byte counts as taken only when valid and ready were both seen at that falling edge. The bench then checks each later value exactly one falling edge afterwards. Ready is swept over a set of patterns: always high, high every second, third and fourth cycle, pseudo-random, and already high before start. Start is poked mid-run to show that the series keeps its place.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  localparam int CMD_W      = 8;
  localparam int STEP_COUNT = 9;
  localparam int STEP_W     = $clog2(STEP_COUNT);

  typedef enum logic [1:0] {
    BANK_DIRECT = 2'b00,
    BANK_ALT    = 2'b01,
    BANK_STATUS = 2'b10
  } bank_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // rewind to first step
    logic advance;  // current step taken
  } seqStrobe_t;

  typedef struct packed {
    logic       rstBit;
    logic [1:0] sysClk;
    logic [2:0] ifFmt;
    logic       dcFilt;
    logic       dacGain;
    logic       adcGain;
    logic       adcPol;
    logic       dacPol;
    logic       dblSpd;
    logic       adcOn;
    logic       dacOn;
    logic [5:0] volume;
    logic [3:0] bass;
    logic [1:0] treble;
    logic [1:0] deemph;
    logic       mute;
    logic [1:0] filtMode;
    logic [2:0] extReg;
    logic [2:0] micGain;
    logic [1:0] mixMode;
  } codecCfg_t;

  typedef struct packed {
    logic [CMD_W-1:0] value;
    logic             isAddr;
  } cmdWord_t;

  function automatic cmdWord_t buildStep(input int idx, input codecCfg_t c,
                                         input logic [5:0] devId);
    cmdWord_t w;
    w.isAddr = 1'b0;
    case (idx)
      0: begin w.value = {devId, BANK_STATUS}; w.isAddr = 1'b1; end
      1: w.value = {1'b0, c.rstBit, c.sysClk, c.ifFmt, c.dcFilt};
      2: w.value = {1'b1, c.dacGain, c.adcGain, c.adcPol, c.dacPol,
                    c.dblSpd, c.adcOn, c.dacOn};
      3: begin w.value = {devId, BANK_DIRECT}; w.isAddr = 1'b1; end
      4: w.value = {2'b00, c.volume};
      5: w.value = {2'b01, c.bass, c.treble};
      6: w.value = {2'b10, 1'b0, c.deemph, c.mute, c.filtMode};
      7: w.value = {5'b11000, c.extReg};
      8: w.value = {3'b111, c.micGain, c.mixMode};
      default: w.value = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/cbs_datapath.sv
module cbs_datapath
  import cbs_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'h05
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  codecCfg_t        cfg,
  output logic [CMD_W-1:0] cmdByte,
  output logic             cmdIsAddr,
  output logic             lastStep
);

  localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(STEP_COUNT - 1);

  logic [STEP_W-1:0] stepIdx;
  cmdWord_t          stepTable [STEP_COUNT];

  genvar gi;
  generate
    for (gi = 0; gi < STEP_COUNT; gi++) begin : g_step
      assign stepTable[gi] = buildStep(gi, cfg, DEV_ID);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (strobe.load) begin
      stepIdx <= '0;
    end else if (strobe.advance && (stepIdx != LAST_IDX)) begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  cmdWord_t curWord;
  always_comb begin
    curWord = '0;
    for (int i = 0; i < STEP_COUNT; i++) begin
      if (stepIdx == STEP_W'(i)) curWord = stepTable[i];
    end
  end

  assign cmdByte   = curWord.value;
  assign cmdIsAddr = curWord.isAddr;
  assign lastStep  = (stepIdx == LAST_IDX);

endmodule

// File: rtl/cbs_control.sv
module cbs_control
  import cbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cmdReady,
  input  logic       lastStep,
  output seqStrobe_t strobe,
  output logic       cmdValid,
  output logic       done
);

  seqState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (cmdReady) begin
          strobe.advance = 1'b1;
          if (lastStep) stateNext = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdValid = (state == ST_RUN);
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
  import cbs_pkg::*;
#(
  parameter logic [5:0] DEV_ID    = 6'h05,
  parameter logic       RST_BIT   = 1'b1,
  parameter logic [1:0] SYS_CLK   = 2'b01,
  parameter logic [2:0] IF_FMT    = 3'b100,
  parameter logic       DC_FILT   = 1'b1,
  parameter logic       DAC_GAIN  = 1'b0,
  parameter logic       ADC_GAIN  = 1'b0,
  parameter logic       ADC_POL   = 1'b0,
  parameter logic       DAC_POL   = 1'b0,
  parameter logic       DBL_SPD   = 1'b0,
  parameter logic       ADC_ON    = 1'b1,
  parameter logic       DAC_ON    = 1'b1,
  parameter logic [5:0] VOLUME    = 6'd0,
  parameter logic [3:0] BASS      = 4'd0,
  parameter logic [1:0] TREBLE    = 2'd0,
  parameter logic [1:0] DEEMPH    = 2'd0,
  parameter logic       MUTE      = 1'b0,
  parameter logic [1:0] FILT_MODE = 2'd0,
  parameter logic [2:0] EXT_REG   = 3'd2,
  parameter logic [2:0] MIC_GAIN  = 3'd6,
  parameter logic [1:0] MIX_MODE  = 2'd1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cmdReady,
  output logic       cmdValid,
  output logic [7:0] cmdByte,
  output logic       cmdIsAddr,
  output logic       done
);

  codecCfg_t  cfg;
  seqStrobe_t strobe;
  logic       lastStep;

  always_comb begin
    cfg          = '0;
    cfg.rstBit   = RST_BIT;
    cfg.sysClk   = SYS_CLK;
    cfg.ifFmt    = IF_FMT;
    cfg.dcFilt   = DC_FILT;
    cfg.dacGain  = DAC_GAIN;
    cfg.adcGain  = ADC_GAIN;
    cfg.adcPol   = ADC_POL;
    cfg.dacPol   = DAC_POL;
    cfg.dblSpd   = DBL_SPD;
    cfg.adcOn    = ADC_ON;
    cfg.dacOn    = DAC_ON;
    cfg.volume   = VOLUME;
    cfg.bass     = BASS;
    cfg.treble   = TREBLE;
    cfg.deemph   = DEEMPH;
    cfg.mute     = MUTE;
    cfg.filtMode = FILT_MODE;
    cfg.extReg   = EXT_REG;
    cfg.micGain  = MIC_GAIN;
    cfg.mixMode  = MIX_MODE;
  end

  cbs_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmdReady (cmdReady),
    .lastStep (lastStep),
    .strobe   (strobe),
    .cmdValid (cmdValid),
    .done     (done)
  );

  cbs_datapath #(.DEV_ID(DEV_ID)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfg       (cfg),
    .cmdByte   (cmdByte),
    .cmdIsAddr (cmdIsAddr),
    .lastStep  (lastStep)
  );

endmodule

// File: rtl/codec_boot_seq_chk.sv
module codec_boot_seq_chk #(
  parameter logic [5:0] DEV_ID = 6'h05
) (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       cmdReady,
  input logic       cmdValid,
  input logic [7:0] cmdByte,
  input logic       cmdIsAddr,
  input logic       done
);

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdByte) && $stable(cmdIsAddr)); // R9

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cmdValid); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done); // R11

  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(cmdValid && cmdReady)); // R10

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid && start |=> cmdValid && cmdIsAddr && (cmdByte[1:0] == 2'b10) && !done); // R2

  AST_ADDR_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdIsAddr |-> cmdByte[7:2] == DEV_ID); // R3

  AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && start && !cmdReady |=> cmdValid && !done); // R12

endmodule

bind codec_boot_seq codec_boot_seq_chk #(.DEV_ID(DEV_ID)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .cmdReady  (cmdReady),
  .cmdValid  (cmdValid),
  .cmdByte   (cmdByte),
  .cmdIsAddr (cmdIsAddr),
  .done      (done)
);

// File: tb/codec_boot_seq_tb.sv
module codec_boot_seq_tb;

  localparam int STEPS = 9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       cmdReady = 1'b0;
  logic       cmdValid;
  logic [7:0] cmdByte;
  logic       cmdIsAddr;
  logic       done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] expB [STEPS];
  bit         expA [STEPS];
  string      reqOf[STEPS];

  always #10 clk = ~clk;

  codec_boot_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdReady(cmdReady),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .cmdIsAddr(cmdIsAddr), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // mode 0: always ready, 1..3: ready every (mode+1)th cycle,
  // 4: pseudo-random, 5: ready already high at the start pulse
  task automatic runSeq(input int mode, input bit poke);
    int         acc;
    int         cyc;
    bit         r;
    bit         hold;
    bit         poked;
    bit         pokeChk;
    logic [7:0] lastB;
    logic [15:0] lf;
    acc = 0; cyc = 0; hold = 0; poked = 0; pokeChk = 0; lastB = '0;
    lf = 16'hACE1 ^ 16'(mode);
    @(negedge clk);
    start = 1'b1;
    cmdReady = (mode == 5);
    @(negedge clk);
    start = 1'b0;
    chk(cmdValid && !done, "R13", "valid/done after start", {cmdValid, done}, 2'b10);
    chk(cmdByte == expB[0] && cmdIsAddr, "R2", "first byte", cmdByte, expB[0]);
    while (!done && cyc < 400) begin
      if (acc == STEPS) begin
        chk(1'b0, "R11", "done late after last byte", done, 1);
        break;
      end
      if (hold) chk(cmdValid && cmdByte == lastB, "R9", "held byte", cmdByte, lastB);
      case (mode)
        0, 5:    r = 1'b1;
        1, 2, 3: r = ((cyc % (mode + 1)) == mode);
        default: r = lf[0];
      endcase
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (poke && !poked && acc == 4) begin
        r = 1'b0; start = 1'b1; poked = 1'b1; pokeChk = 1'b1;
      end
      cmdReady = r;
      if (r) begin
        chk(cmdValid && cmdByte == expB[acc], reqOf[acc],
            $sformatf("byte %0d (order R8)", acc), cmdByte, expB[acc]);
        chk(cmdIsAddr == expA[acc], "R3", $sformatf("phase flag %0d", acc),
            cmdIsAddr, expA[acc]);
        acc++;
      end
      hold = !r;
      lastB = cmdByte;
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (pokeChk) begin
        chk(cmdValid && !done && cmdByte == lastB, "R12", "start mid-run", cmdByte, lastB);
        pokeChk = 0;
      end
    end
    cmdReady = 1'b0;
    chk(acc == STEPS, "R10", "bytes taken", acc, STEPS);
    chk(done && !cmdValid, "R11", "done/valid at end", {done, cmdValid}, 2'b10);
    repeat (3) @(negedge clk);
    chk(done && !cmdValid, "R11", "done sticky", {done, cmdValid}, 2'b10);
  endtask

  initial begin
    expB[0] = 8'h14 | 8'h02;
    expB[1] = 8'h40 | (8'd1 << 4) | (8'd4 << 1) | 8'd1;
    expB[2] = 8'h80 | 8'h02 | 8'h01;
    expB[3] = 8'h14 | 8'h00;
    expB[4] = 8'h00 | 8'd0;
    expB[5] = 8'h40 | (8'd0 << 2) | 8'd0;
    expB[6] = 8'h80 | (8'd0 << 3) | (8'd0 << 2) | 8'd0;
    expB[7] = 8'hC0 | 8'd2;
    expB[8] = 8'hE0 | (8'd6 << 2) | 8'd1;
    for (int i = 0; i < STEPS; i++) expA[i] = (i == 0) || (i == 3);
    reqOf[0] = "R3"; reqOf[1] = "R4"; reqOf[2] = "R5"; reqOf[3] = "R3";
    reqOf[4] = "R6"; reqOf[5] = "R6"; reqOf[6] = "R6";
    reqOf[7] = "R7"; reqOf[8] = "R7";

    start = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cmdValid && !done, "R1", "outputs in reset", {cmdValid, done}, 0);
    rstN = 1'b1;
    start = 1'b0;
    @(negedge clk);
    chk(!cmdValid && !done, "R1", "outputs after reset", {cmdValid, done}, 0);

    // ready high while idle must not move anything
    cmdReady = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cmdValid && !done, "R10", "idle with ready", {cmdValid, done}, 0);
    cmdReady = 1'b0;

    for (int m = 0; m < 6; m++) runSeq(m, 1'b0);
    for (int m = 0; m < 5; m++) runSeq(m, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule